// File: doc/BRIEF.md
# Seconds-Locked Pulse Output Generator

This block turns the seconds and nanoseconds values of a local time counter into a square wave with a period of one second. It drives that wave onto any of a set of general-purpose pins whose function word selects it. The wave is not timed by a counter of its own. Its level comes straight from the nanoseconds value, and the seconds value marks where each period starts. Any step or slew applied to the time counter therefore moves the output with it, and nothing has to be reprogrammed. Period, start time and duty cycle are fixed. The only phase control is a polarity input, which moves the rising edge by half a second.

Configuration gives an enable bit and a polarity bit. After enable rises, the output stays at its low level until the seconds value next changes, so the first pulse is always a whole one. While disabled, each selected pin still drives a low level and does not float.

Top module: `pps_gen`

## Requirements
- R1: While reset is asserted and on the first cycle after it, every pin output and every pin drive enable is 0.
- R2: While running with polarity 0, a selected pin is 1 when the nanoseconds input is below 500,000,000 (499,999,999 gives 1) and 0 from 500,000,000 upward.
- R3: With polarity 1 the running level is inverted: 0 in the first half of the second and 1 in the second half, which gives a half-second phase shift.
- R4: While the enable input is 0, every pin output is 0 whatever the polarity and nanoseconds values are, and a selected pin keeps its drive enable at 1.
- R5: After the enable input rises, the outputs stay 0 until the seconds input differs from its value in the previous cycle. From the cycle in which it changes, the level follows R2 and R3.
- R6: Once running, an arbitrary change of the seconds and nanoseconds inputs, forward or backward, is reflected by the level that the new nanoseconds value implies, with no re-arming and no extra pulse.
- R7: Pin i takes bits [16i+15:16i] of the function bus. It is selected only when bit 15 is 1, bit 6 is 1 and bits [5:0] equal 0x12. All other bits are ignored. A pin that is not selected has output 0 and drive enable 0.
- R8: Every output is registered and reflects the inputs sampled at the previous rising clock edge (one cycle of latency).
- R9: Dropping the enable input and raising it again re-arms the wait of R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| secIn | input | SEC_W (48) | Seconds value of the time counter |
| nsecIn | input | NS_W (30) | Nanoseconds value of the time counter |
| cfgEnable | input | 1 | Output enable |
| cfgPolarity | input | 1 | Polarity, 1 = half-second shifted |
| pinFuncCfg | input | NUM_PINS*16 (64) | Function word of each pin, pin 0 in the lowest bits |
| pinOut | output | NUM_PINS (4) | Pin output levels |
| pinDriveEn | output | NUM_PINS (4) | Pin drive enables |

## Verification
Every output is due exactly one rising edge after the inputs that cause it. The bench changes inputs on the falling edge and samples outputs on the next falling edge, so each result is read half a period after the edge that produced it. The reference model advances on each rising edge from the inputs it sees there, and it is compared with the pins on every falling edge. Directed checks therefore read the result one cycle after a step. Checks of the arming wait read it several cycles later, to show that nothing appears before the seconds value changes.

// File: rtl/pps_pkg.sv
package pps_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_RUN   = 2'd2
  } ppsState_t;

  typedef struct packed {
    logic drive;
  } ctlStrobes_t;

  typedef struct packed {
    logic secTick;
  } datStatus_t;

endpackage

// File: rtl/pps_ctrl.sv
module pps_ctrl
  import pps_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgEnable,
  input  datStatus_t  sts,
  output ctlStrobes_t ctl
);

  ppsState_t state, stateNext;

  always_comb begin
    stateNext = state;
    if (!cfgEnable) begin
      stateNext = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE:  stateNext = ST_ARMED;
        ST_ARMED: stateNext = sts.secTick ? ST_RUN : ST_ARMED;
        ST_RUN:   stateNext = ST_RUN;
        default:  stateNext = ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.drive = cfgEnable &&
                ((state == ST_RUN) || ((state == ST_ARMED) && sts.secTick));
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

endmodule

// File: rtl/pps_datapath.sv
module pps_datapath
  import pps_pkg::*;
#(
  parameter int SEC_W    = 48,
  parameter int NS_W     = 30,
  parameter int HALF_NS  = 500_000_000,
  parameter int NUM_PINS = 4,
  parameter int FUNC_W   = 16,
  parameter int EN_BIT   = 15,
  parameter int PTP_BIT  = 6,
  parameter int CODE_W   = 6,
  parameter int SIG_CODE = 'h12
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [SEC_W-1:0]           secIn,
  input  logic [NS_W-1:0]            nsecIn,
  input  logic                       cfgPolarity,
  input  logic [NUM_PINS*FUNC_W-1:0] pinFuncCfg,
  input  ctlStrobes_t                ctl,
  output datStatus_t                 sts,
  output logic [NUM_PINS-1:0]        pinOut,
  output logic [NUM_PINS-1:0]        pinDriveEn
);

  localparam logic [NS_W-1:0]   HALF_VAL  = NS_W'(HALF_NS);
  localparam logic [FUNC_W-1:0] SEL_MASK  = FUNC_W'((1 << EN_BIT) | (1 << PTP_BIT) |
                                                    ((1 << CODE_W) - 1));
  localparam logic [FUNC_W-1:0] SEL_MATCH = FUNC_W'((1 << EN_BIT) | (1 << PTP_BIT) |
                                                    SIG_CODE);

  logic [SEC_W-1:0] secPrev;
  logic             firstHalf;
  logic             waveLvl;

  always_ff @(posedge clk) begin
    if (!rstN) secPrev <= '0;
    else       secPrev <= secIn;
  end

  always_comb begin
    sts.secTick = (secIn != secPrev);
    firstHalf   = (nsecIn < HALF_VAL);
    waveLvl     = ctl.drive & (firstHalf ^ cfgPolarity);
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic [FUNC_W-1:0] funcWord;
    logic              pinSel;

    always_comb begin
      funcWord = pinFuncCfg[i*FUNC_W +: FUNC_W];
      pinSel   = ((funcWord & SEL_MASK) == SEL_MATCH);
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        pinOut[i]     <= 1'b0;
        pinDriveEn[i] <= 1'b0;
      end else begin
        pinOut[i]     <= pinSel & waveLvl;
        pinDriveEn[i] <= pinSel;
      end
    end
  end

endmodule

// File: rtl/pps_gen.sv
module pps_gen
  import pps_pkg::*;
#(
  parameter int SEC_W    = 48,
  parameter int NS_W     = 30,
  parameter int HALF_NS  = 500_000_000,
  parameter int NUM_PINS = 4,
  parameter int FUNC_W   = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [SEC_W-1:0]           secIn,
  input  logic [NS_W-1:0]            nsecIn,
  input  logic                       cfgEnable,
  input  logic                       cfgPolarity,
  input  logic [NUM_PINS*FUNC_W-1:0] pinFuncCfg,
  output logic [NUM_PINS-1:0]        pinOut,
  output logic [NUM_PINS-1:0]        pinDriveEn
);

  ctlStrobes_t ctl;
  datStatus_t  sts;

  pps_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cfgEnable (cfgEnable),
    .sts       (sts),
    .ctl       (ctl)
  );

  pps_datapath #(
    .SEC_W    (SEC_W),
    .NS_W     (NS_W),
    .HALF_NS  (HALF_NS),
    .NUM_PINS (NUM_PINS),
    .FUNC_W   (FUNC_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .secIn       (secIn),
    .nsecIn      (nsecIn),
    .cfgPolarity (cfgPolarity),
    .pinFuncCfg  (pinFuncCfg),
    .ctl         (ctl),
    .sts         (sts),
    .pinOut      (pinOut),
    .pinDriveEn  (pinDriveEn)
  );

endmodule

// File: rtl/pps_checker.sv
module pps_checker #(
  parameter int NUM_PINS = 4,
  parameter int FUNC_W   = 16
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       cfgEnable,
  input logic [NUM_PINS*FUNC_W-1:0] pinFuncCfg,
  input logic [NUM_PINS-1:0]        pinOut,
  input logic [NUM_PINS-1:0]        pinDriveEn
);

  logic [1:0] upCnt;
  logic       upReady;

  always_ff @(posedge clk) begin
    if (!rstN)               upCnt <= 2'd0;
    else if (upCnt != 2'd3)  upCnt <= upCnt + 2'd1;
  end

  assign upReady = (upCnt >= 2'd2);

  // R4: a disabled cycle yields low pins on the following cycle
  a_r4_disabled_low: assert property (@(posedge clk) disable iff (!rstN)
    (upReady && !$past(cfgEnable)) |-> (pinOut == '0));

  // R5: the cycle after enable rises never carries a pulse
  a_r5_armed_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (upReady && $rose(cfgEnable)) |=> (pinOut == '0));

  // R7: an undriven pin never shows a high level
  a_r7_unsel_quiet: assert property (@(posedge clk) disable iff (!rstN)
    upReady |-> ((pinOut & ~pinDriveEn) == '0));

  // R8: drive enables move only one cycle after the function words move
  a_r8_oe_latency: assert property (@(posedge clk) disable iff (!rstN)
    (upReady && $stable(pinFuncCfg)) |=> $stable(pinDriveEn));

endmodule

bind pps_gen pps_checker #(.NUM_PINS(NUM_PINS), .FUNC_W(FUNC_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .cfgEnable  (cfgEnable),
  .pinFuncCfg (pinFuncCfg),
  .pinOut     (pinOut),
  .pinDriveEn (pinDriveEn)
);

// File: tb/tb_pps_gen.sv
`timescale 1ns/1ps
module tb_pps_gen;

  localparam int NP = 4;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic [47:0]    secIn = '0;
  logic [29:0]    nsecIn = '0;
  logic           cfgEnable = 1'b0;
  logic           cfgPolarity = 1'b0;
  logic [15:0]    cfgWord [NP];
  logic [NP*16-1:0] pinFuncCfg;
  logic [NP-1:0]  pinOut, pinDriveEn;

  int checks = 0;
  int fails = 0;
  string curReq = "R1";

  always #2 clk = ~clk;

  always_comb
    for (int i = 0; i < NP; i++) pinFuncCfg[i*16 +: 16] = cfgWord[i];

  pps_gen dut (
    .clk(clk), .rstN(rstN), .secIn(secIn), .nsecIn(nsecIn),
    .cfgEnable(cfgEnable), .cfgPolarity(cfgPolarity),
    .pinFuncCfg(pinFuncCfg), .pinOut(pinOut), .pinDriveEn(pinDriveEn)
  );

  // behavioural reference: 0 off, 1 waiting for seconds change, 2 running
  int          mMode = 0;
  logic [47:0] mLastSec = '0;
  logic [NP-1:0] expOut = '0, expOe = '0;

  function automatic bit isPpsPin(logic [15:0] w);
    return w[15] && w[6] && (w[5:0] == 6'h12);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mMode = 0; mLastSec = '0; expOut = '0; expOe = '0;
    end else begin
      bit changed, high, on;
      changed = (secIn != mLastSec);
      high    = (nsecIn < 30'd500_000_000) ? !cfgPolarity : cfgPolarity;
      on      = cfgEnable && (mMode == 2 || (mMode == 1 && changed));
      for (int i = 0; i < NP; i++) begin
        expOe[i]  = isPpsPin(cfgWord[i]);
        expOut[i] = expOe[i] && on && high;
      end
      if (!cfgEnable)     mMode = 0;
      else if (mMode == 0) mMode = 1;
      else if (mMode == 1 && changed) mMode = 2;
      mLastSec = secIn;
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      checks++;
      if (pinOut !== expOut || pinDriveEn !== expOe) begin
        fails++;
        $display("FAIL model %s: out=%b oe=%b expected out=%b oe=%b",
                 curReq, pinOut, pinDriveEn, expOut, expOe);
      end
    end
  end

  task automatic chk(string req, logic [NP-1:0] gotV, logic [NP-1:0] expV);
    checks++;
    if (gotV !== expV) begin
      fails++;
      $display("FAIL %s: actual=%b expected=%b", req, gotV, expV);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    int unsigned x;
    for (int i = 0; i < NP; i++) cfgWord[i] = '0;
    cyc(3);
    chk("R1 out in reset", pinOut, 4'b0000);
    chk("R1 oe in reset", pinDriveEn, 4'b0000);
    rstN = 1'b1;
    cyc(1);
    chk("R1 out after reset", pinOut, 4'b0000);
    chk("R1 oe after reset", pinDriveEn, 4'b0000);

    curReq = "R7";
    cfgWord[0] = 16'h8052; cfgWord[1] = 16'h0000;
    cfgWord[2] = 16'h8012; cfgWord[3] = 16'hFFD2;
    secIn = 48'd5; nsecIn = 30'd100;
    cyc(1);
    chk("R7 selected drive enables", pinDriveEn, 4'b1001);
    chk("R8 one cycle oe latency", pinDriveEn, 4'b1001);
    curReq = "R4";
    cyc(1);
    chk("R4 disabled pol0 low", pinOut, 4'b0000);
    cfgPolarity = 1'b1; nsecIn = 30'd900_000_000;
    cyc(2);
    chk("R4 disabled pol1 low", pinOut, 4'b0000);
    chk("R4 disabled still driven", pinDriveEn, 4'b1001);

    curReq = "R5";
    cfgPolarity = 1'b0; nsecIn = 30'd100; cfgEnable = 1'b1;
    cyc(4);
    chk("R5 armed no pulse before tick", pinOut, 4'b0000);
    secIn = 48'd6; nsecIn = 30'd0;
    cyc(1);
    chk("R5 R8 pulse one cycle after tick", pinOut, 4'b1001);

    curReq = "R2";
    nsecIn = 30'd499_999_999; cyc(1);
    chk("R2 just below half high", pinOut, 4'b1001);
    nsecIn = 30'd500_000_000; cyc(1);
    chk("R2 at half low", pinOut, 4'b0000);
    nsecIn = 30'd999_999_999; cyc(1);
    chk("R2 end of second low", pinOut, 4'b0000);

    curReq = "R3";
    cfgPolarity = 1'b1;
    nsecIn = 30'd500_000_000; cyc(1);
    chk("R3 inverted at half high", pinOut, 4'b1001);
    nsecIn = 30'd10; cyc(1);
    chk("R3 inverted early low", pinOut, 4'b0000);

    curReq = "R6";
    cfgPolarity = 1'b0;
    nsecIn = 30'd700_000_000; cyc(1);
    chk("R6 late second low", pinOut, 4'b0000);
    nsecIn = 30'd200_000_000; cyc(1);
    chk("R6 backward step same second", pinOut, 4'b1001);
    secIn = 48'd100; nsecIn = 30'd800_000_000; cyc(1);
    chk("R6 forward jump", pinOut, 4'b0000);
    secIn = 48'd3; nsecIn = 30'd1; cyc(1);
    chk("R6 backward seconds step", pinOut, 4'b1001);

    curReq = "R9";
    cfgEnable = 1'b0; cyc(1);
    chk("R4 disable drops output", pinOut, 4'b0000);
    chk("R4 disable keeps oe", pinDriveEn, 4'b1001);
    cfgEnable = 1'b1; nsecIn = 30'd5; cyc(3);
    chk("R9 re-armed waits", pinOut, 4'b0000);
    secIn = 48'd4; cyc(1);
    chk("R9 resumes on tick", pinOut, 4'b1001);

    curReq = "R7";
    cfgWord[1] = 16'h8052; cyc(1);
    chk("R7 new pin selected out", pinOut, 4'b1011);
    chk("R7 new pin selected oe", pinDriveEn, 4'b1011);
    cfgWord[0] = 16'h8053; cyc(1);
    chk("R7 wrong code deselects", pinDriveEn, 4'b1010);
    chk("R7 deselected pin low", pinOut, 4'b1010);
    cfgWord[3] = 16'h0052; cyc(1);
    chk("R7 missing enable bit", pinDriveEn, 4'b0010);

    curReq = "R6 sweep";
    cfgWord[0] = 16'h8052; cfgWord[3] = 16'h8052;
    x = 32'd12345;
    for (int k = 0; k < 400; k++) begin
      x = x * 32'd1103515245 + 32'd12345;
      nsecIn = 30'(x % 32'd1_000_000_000);
      if (x[27:25] == 3'd0) secIn = secIn + 48'd1;
      if (x[31:28] == 4'd0) cfgEnable = ~cfgEnable;
      if (x[24:21] == 4'd1) cfgPolarity = ~cfgPolarity;
      cyc(1);
    end
    cyc(1);
    finishRun();
  end

endmodule